// File: doc/BRIEF.md
# Sliced Byte Gather Unit

The unit performs a table gather over bytes. For every lane i of an index vector it returns the table byte addressed by that lane's index: `out[i] = T[S[i]]`. The index vector holds m lanes and the table holds n entries. Both sizes are multiples of 16, up to 64, and are chosen per operation by size codes. The only lookup element is a fixed 16-lane byte shuffle. That shuffle wraps its selector to the low four bits and returns element 0 whenever the selector's top bit is set.

A wide table is cut into 16-entry slices, with one slice handled per clock. In each slice cycle, every 16-lane index group is shuffled against the current slice in parallel. A per-lane compare on the index value then decides whether that partial result is blended into the lane's running result. Before the slicing starts, indices are reduced modulo n. This lets out-of-range values, including those with the top bit set, wrap correctly.

An optional mode keeps the shuffle's native rule instead: any index with its top bit set returns entry 0. Because the operation is a composition of lookups, chaining two gathers through the unit gives the same answer in either grouping.

Top module: `gshuf_gather`

## Requirements
- R1: After reset, out_valid and busy are 0 and out_vec is all zero.
- R2: With neg_zero = 0, lane i < m of out_vec equals table entry (idx_i mod n) for every index value 0..255, including 127, 128 and 255. Lane i occupies bits [8i+7:8i] of both idx_vec and out_vec, and entry e occupies bits [8e+7:8e] of tbl_vec.
- R3: Table entries at positions n and above never appear in the result.
- R4: Result lanes i >= m are zero.
- R5: With neg_zero = 1, a lane whose index has bit 7 set returns table entry 0, and lanes with bit 7 clear follow R2.
- R6: m = 16*(m_sel+1) and n = 16*(n_sel+1). A start seen while busy is 0 is accepted. busy is then 1 for exactly n/16 cycles, and out_valid is a one-cycle pulse in the cycle busy returns to 0.
- R7: A start raised while busy is 1 is ignored: the running operation's result and timing are unchanged.
- R8: out_vec changes only in the cycle out_valid is 1 and holds otherwise.
- R9: Gathers compose associatively: gather(gather(S,T),U) equals gather(S,gather(T,U)) when produced by the unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation using the present inputs |
| m_sel | input | 2 | Index lane count code, m = 16*(m_sel+1) |
| n_sel | input | 2 | Table size code, n = 16*(n_sel+1) |
| neg_zero | input | 1 | 1: an index with bit 7 set returns entry 0 |
| idx_vec | input | 512 | Index bytes, lane i at [8i+7:8i] |
| tbl_vec | input | 512 | Table bytes, entry e at [8e+7:8e] |
| busy | output | 1 | Operation in progress |
| out_vec | output | 512 | Result bytes, lane i at [8i+7:8i] |
| out_valid | output | 1 | One-cycle result strobe |

## Verification
Suppose start is sampled at clock edge E. busy is then high after edges E through E+n/16-1, and both the result and out_valid appear after edge E+n/16. One further edge later, out_valid falls while out_vec holds.

The bench keeps a behavioural model that counts cycles from the accepted start. At every falling edge it compares busy and out_valid against that count. It compares out_vec in the cycle the model expects the strobe, and again in the following cycle. The result itself is computed by direct array indexing, with a modulo by n.

// File: rtl/gshuf_pkg.sv
package gshuf_pkg;
    localparam int LANES = 16;
    localparam int BW    = 8;
    localparam int LW    = $clog2(LANES);
    localparam int GBITS = LANES * BW;
    localparam int MAX_SUB = 256 / LANES - 1;

    typedef logic [BW-1:0] byte_t;

    typedef struct packed {
        logic       busy;
        logic       valid;
        logic [1:0] cnt;
        logic [1:0] last;
        logic [1:0] mlast;
    } ctl_t;

    // Reduce a raw index into the table range; flag it when the native
    // top-bit rule of the shuffle is requested.
    function automatic byte_t cond_index(byte_t raw, byte_t nsize, logic nz);
        byte_t v;
        if (nz && raw[BW-1]) begin
            v = byte_t'(1) << (BW - 1);
        end else begin
            v = raw;
            for (int s = 0; s < MAX_SUB; s++) begin
                if (v >= nsize) v = v - nsize;
            end
        end
        return v;
    endfunction

    function automatic byte_t size_bytes(logic [1:0] code);
        return byte_t'((32'(code) + 1) * LANES);
    endfunction
endpackage

// File: rtl/gshuf_prim.sv
module gshuf_prim
    import gshuf_pkg::*;
(
    input  logic [GBITS-1:0] sel_i,
    input  logic [GBITS-1:0] tbl_i,
    output logic [GBITS-1:0] res_o
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        byte_t ix;
        logic [LW-1:0] wrap;
        assign ix   = sel_i[j*BW +: BW];
        assign wrap = ix[LW-1:0];
        assign res_o[j*BW +: BW] = ix[BW-1] ? tbl_i[0 +: BW]
                                            : tbl_i[wrap*BW +: BW];
    end
endmodule

// File: rtl/gshuf_cond.sv
module gshuf_cond
    import gshuf_pkg::*;
#(
    parameter int NLANE = 64
) (
    input  logic [NLANE*BW-1:0] raw_i,
    input  byte_t               nsize_i,
    input  logic                nz_i,
    output logic [NLANE*BW-1:0] cond_o
);
    for (genvar i = 0; i < NLANE; i++) begin : g_idx
        assign cond_o[i*BW +: BW] = cond_index(raw_i[i*BW +: BW], nsize_i, nz_i);
    end
endmodule

// File: rtl/gshuf_group.sv
module gshuf_group
    import gshuf_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic [GBITS-1:0] sel_i,
    input  logic [GBITS-1:0] slice_i,
    input  logic [CW-1:0]    cnt_i,
    input  logic [GBITS-1:0] acc_i,
    output logic [GBITS-1:0] acc_o
);
    logic [GBITS-1:0] part;

    gshuf_prim u_prim (
        .sel_i (sel_i),
        .tbl_i (slice_i),
        .res_o (part)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_blend
        byte_t ix;
        logic  hit;
        assign ix  = sel_i[j*BW +: BW];
        assign hit = ix[BW-1] ? (cnt_i == '0) : ((ix >> LW) == byte_t'(cnt_i));
        assign acc_o[j*BW +: BW] = hit ? part[j*BW +: BW] : acc_i[j*BW +: BW];
    end
endmodule

// File: rtl/gshuf_gather.sv
module gshuf_gather
    import gshuf_pkg::*;
#(
    parameter int MAX_M = 64,
    parameter int MAX_N = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [1:0]         m_sel,
    input  logic [1:0]         n_sel,
    input  logic               neg_zero,
    input  logic [MAX_M*8-1:0] idx_vec,
    input  logic [MAX_N*8-1:0] tbl_vec,
    output logic               busy,
    output logic [MAX_M*8-1:0] out_vec,
    output logic               out_valid
);
    localparam int MG = MAX_M / LANES;
    localparam int NS = MAX_N / LANES;
    localparam int IW = MAX_M * BW;
    localparam int TW = MAX_N * BW;

    ctl_t          ctl_q;
    logic [IW-1:0] idx_q;
    logic [TW-1:0] tbl_q;
    logic [IW-1:0] acc_q;
    logic [IW-1:0] acc_nx;
    logic [IW-1:0] res_nx;
    logic [IW-1:0] out_q;
    logic [IW-1:0] idx_c;
    logic [GBITS-1:0] slice;
    byte_t         nsize;
    logic          accept;
    logic          finish;

    assign nsize  = size_bytes(n_sel);
    assign accept = start && !ctl_q.busy;
    assign finish = ctl_q.busy && (ctl_q.cnt == ctl_q.last);

    gshuf_cond #(.NLANE(MAX_M)) u_cond (
        .raw_i   (idx_vec),
        .nsize_i (nsize),
        .nz_i    (neg_zero),
        .cond_o  (idx_c)
    );

    always_comb begin
        slice = '0;
        for (int k = 0; k < NS; k++) begin
            if (ctl_q.cnt == 2'(k)) slice = tbl_q[k*GBITS +: GBITS];
        end
    end

    for (genvar g = 0; g < MG; g++) begin : g_grp
        gshuf_group #(.CW(2)) u_grp (
            .sel_i   (idx_q[g*GBITS +: GBITS]),
            .slice_i (slice),
            .cnt_i   (ctl_q.cnt),
            .acc_i   (acc_q[g*GBITS +: GBITS]),
            .acc_o   (acc_nx[g*GBITS +: GBITS])
        );
        assign res_nx[g*GBITS +: GBITS] =
            (2'(g) <= ctl_q.mlast) ? acc_nx[g*GBITS +: GBITS] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            idx_q <= '0;
            tbl_q <= '0;
            acc_q <= '0;
            out_q <= '0;
        end else begin
            ctl_q.valid <= 1'b0;
            if (accept) begin
                ctl_q.busy  <= 1'b1;
                ctl_q.cnt   <= '0;
                ctl_q.last  <= n_sel;
                ctl_q.mlast <= m_sel;
                idx_q       <= idx_c;
                tbl_q       <= tbl_vec;
                acc_q       <= '0;
            end else if (ctl_q.busy) begin
                acc_q <= acc_nx;
                if (finish) begin
                    ctl_q.busy  <= 1'b0;
                    ctl_q.valid <= 1'b1;
                    out_q       <= res_nx;
                end else begin
                    ctl_q.cnt <= ctl_q.cnt + 2'd1;
                end
            end
        end
    end

    assign busy      = ctl_q.busy;
    assign out_valid = ctl_q.valid;
    assign out_vec   = out_q;
endmodule

// File: rtl/gshuf_gather_chk.sv
module gshuf_gather_chk #(
    parameter int OW = 512
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          out_valid,
    input logic [OW-1:0] out_vec
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !busy && out_vec == '0));

    assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_valid_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(busy) && !busy));

    assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_vec));
endmodule

bind gshuf_gather gshuf_gather_chk #(.OW(MAX_M*8)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/gshuf_gather_tb.sv
module gshuf_gather_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   m_sel = 2'd0;
    logic [1:0]   n_sel = 2'd0;
    logic         neg_zero = 1'b0;
    logic [511:0] idx_vec = '0;
    logic [511:0] tbl_vec = '0;
    logic         busy;
    logic [511:0] out_vec;
    logic         out_valid;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    gshuf_gather u_dut (
        .clk(clk), .rst(rst), .start(start), .m_sel(m_sel), .n_sel(n_sel),
        .neg_zero(neg_zero), .idx_vec(idx_vec), .tbl_vec(tbl_vec),
        .busy(busy), .out_vec(out_vec), .out_valid(out_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [511:0] model(input logic [511:0] s, input logic [511:0] t,
                                           input int mc, input int nc, input bit nz);
        logic [511:0] r = '0;
        int m = 16 * (mc + 1);
        int n = 16 * (nc + 1);
        for (int i = 0; i < m; i++) begin
            int v = int'(s[i*8 +: 8]);
            if (nz && v >= 128) r[i*8 +: 8] = t[0 +: 8];
            else                r[i*8 +: 8] = t[(v % n)*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // One operation; the cycle model counts edges from the accepted start.
    task automatic run(input logic [511:0] s, input logic [511:0] t, input int mc,
                       input int nc, input bit nz, input bit extra, input string req,
                       output logic [511:0] got);
        logic [511:0] exp = model(s, t, mc, nc, nz);
        int nsl = nc + 1;
        @(negedge clk);
        idx_vec = s; tbl_vec = t; m_sel = 2'(mc); n_sel = 2'(nc);
        neg_zero = nz; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= nsl; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (extra && k == 1) begin
                // R7: second start while busy, with other data
                idx_vec = ~s; tbl_vec = ~t; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            check(busy == (k < nsl), "R6", "busy", 512'(busy), 512'(k < nsl));
            check(out_valid == (k == nsl), "R6", "out_valid", 512'(out_valid),
                  512'(k == nsl));
        end
        start = 1'b0;
        check(out_vec == exp, req, "result", out_vec, exp);
        got = out_vec;
        @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R6", "pulse end", 512'(out_valid), 512'(0));
        check(out_vec == exp, "R8", "hold after strobe", out_vec, exp);
    endtask

    initial begin
        logic [511:0] s, t, u, a, b, c, d, got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !busy, "R1", "ctrl after reset",
              512'({busy, out_valid}), 512'(0));
        check(out_vec == '0, "R1", "out after reset", out_vec, '0);

        // R2: full size with boundary indices 127, 128, 255
        s = rnd512(); t = rnd512();
        s[0 +: 8] = 8'd127; s[8 +: 8] = 8'd128; s[16 +: 8] = 8'd255;
        s[24 +: 8] = 8'd63; s[32 +: 8] = 8'd64; s[40 +: 8] = 8'd0;
        run(s, t, 3, 3, 1'b0, 1'b0, "R2", got);
        check(got[0 +: 8] == t[63*8 +: 8], "R2", "idx 127", 512'(got[0 +: 8]),
              512'(t[63*8 +: 8]));
        check(got[8 +: 8] == t[0 +: 8], "R2", "idx 128", 512'(got[8 +: 8]),
              512'(t[0 +: 8]));
        check(got[16 +: 8] == t[63*8 +: 8], "R2", "idx 255", 512'(got[16 +: 8]),
              512'(t[63*8 +: 8]));

        // R3 and R4: n = 48, m = 32; entries beyond n carry a marker value
        s = rnd512(); t = rnd512();
        t[48*8 +: 128] = {16{8'hEE}};
        for (int i = 0; i < 64; i++) if (t[i*8 +: 8] == 8'hEE && i < 48) t[i*8 +: 8] = 8'h11;
        run(s, t, 1, 2, 1'b0, 1'b0, "R3", got);
        begin
            bit clean = 1;
            for (int i = 0; i < 32; i++) if (got[i*8 +: 8] == 8'hEE) clean = 0;
            check(clean, "R3", "no entry beyond n", got, model(s, t, 1, 2, 1'b0));
        end
        check(got[511:256] == '0, "R4", "lanes past m", 512'(got[511:256]), '0);

        // R2: smallest sizes
        s = rnd512(); t = rnd512();
        run(s, t, 0, 0, 1'b0, 1'b0, "R2", got);
        check(got[511:128] == '0, "R4", "lanes past m=16", 512'(got[511:128]), '0);

        // R5: native top-bit rule
        s = rnd512(); t = rnd512();
        s[0 +: 8] = 8'd128; s[8 +: 8] = 8'd255; s[16 +: 8] = 8'd127;
        run(s, t, 3, 1, 1'b1, 1'b0, "R5", got);
        check(got[8 +: 8] == t[0 +: 8], "R5", "idx 255 gives entry 0",
              512'(got[8 +: 8]), 512'(t[0 +: 8]));

        // R7: start while busy
        s = rnd512(); t = rnd512();
        run(s, t, 3, 3, 1'b0, 1'b1, "R7", got);
        @(negedge clk);
        check(!busy && !out_valid, "R7", "no second operation",
              512'({busy, out_valid}), 512'(0));

        // R8: inputs change, no start, output holds
        idx_vec = rnd512(); tbl_vec = rnd512();
        repeat (5) @(negedge clk);
        check(out_vec == got, "R8", "hold while idle", out_vec, got);

        // R9: associativity through the unit
        s = rnd512(); t = rnd512(); u = rnd512();
        run(s, t, 3, 3, 1'b0, 1'b0, "R2", a);
        run(a, u, 3, 3, 1'b0, 1'b0, "R9", b);
        run(t, u, 3, 3, 1'b0, 1'b0, "R2", c);
        run(s, c, 3, 3, 1'b0, 1'b0, "R9", d);
        check(b == d, "R9", "both groupings", b, d);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule